// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives the six gate signals of a three-leg inverter from one shared up/down counter. Each leg has a high-side and a low-side output. A leg's duty value sets a threshold that the counter is compared against. The two sides of a leg are kept apart by a programmable dead band, so both switches of a leg are never on together.

Period, dead time, minimum pulse width, the three duty values and the output mask are captured into shadow registers at the start of each PWM period. In double-update mode they are captured again at the period midpoint. The mask gives each output its own disable bit and each leg a crossover bit that swaps its two sides, which supports block commutation of brushless motors.

A free-running chopping wave can be ANDed into the high-side outputs, the low-side outputs, or both, for pulse-transformer gate drives. A one-cycle synchronisation pulse marks the start of every period. An interrupt request pulse follows it on the next cycle.

Top module: `tri_phase_pwm`

## Requirements
- R1: While `rstN` is low, all six gate outputs, `syncPulse` and `pwmIrq` are low.
- R2: With captured period value P (P ≥ 1), each PWM period lasts exactly 2·P clock cycles. `syncPulse` is high for exactly its first cycle. The first period begins on the first clock edge after reset is released.
- R3: `pwmIrq` is high for exactly one cycle in each period: the cycle right after the `syncPulse` cycle.
- R4: The counter counts up from 0 to P−1 and then back down from P−1 to 0, so each counter value is visited twice per period. For duty d and dead value t, each half period contributes the following on-time (a negative width counts as 0, and a width above P counts as P):
  - high side: d−t cycles;
  - low side: P−d−t cycles.
- R5: After a high-side output turns off, its low-side partner turns on exactly 2·t cycles later. With t = 0 it turns on in the same cycle. Both outputs of a leg are never high in the same cycle.
- R6: When `dblMode` = 0, the captured values change only at the start of a period. A value written during a period takes effect at the start of the next period.
- R7: When `dblMode` = 1, the captured values are also reloaded at the midpoint, so the falling half of the current period uses values written during its rising half.
- R8: If a side's half-period width (d−t for high, P−d−t for low) is below `minPulseIn`, that side stays off for the whole half.
- R9: Mask bits 8, 7 and 6 swap the high and low signals of legs A, B and C respectively. The swap happens before the disable bits are applied.
- R10: Mask bits 5, 4, 3, 2, 1 and 0 force off outputs AH, AL, BL, BH, CH and CL respectively. For example, 0x0A7 switches off AH, BH, CH and CL and crosses over leg B.
- R11: A chopping wave starts low at reset and toggles every `chopDiv`+1 cycles. While `chopHiEn` = 1 it gates all high-side outputs. While `chopLoEn` = 1 it gates all low-side outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periodIn | input | 16 | Half-period length P in clock cycles |
| deadIn | input | 10 | Dead value t; the dead band is 2·t cycles |
| minPulseIn | input | 10 | Minimum half-period pulse width |
| dutyA | input | 16 | Duty value of leg A |
| dutyB | input | 16 | Duty value of leg B |
| dutyC | input | 16 | Duty value of leg C |
| segMask | input | 9 | Crossover bits [8:6] and disable bits [5:0] |
| dblMode | input | 1 | 1 = reload the captured values at the midpoint as well |
| chopHiEn | input | 1 | Chop the high-side outputs |
| chopLoEn | input | 1 | Chop the low-side outputs |
| chopDiv | input | 8 | Chopping half-period minus one |
| gateHi | output | 3 | High-side gates; bit 0 = A, bit 1 = B, bit 2 = C |
| gateLo | output | 3 | Low-side gates; bit 0 = A, bit 1 = B, bit 2 = C |
| syncPulse | output | 1 | One-cycle start-of-period marker |
| pwmIrq | output | 1 | One-cycle interrupt request after the sync pulse |

## Verification
The bench measures on-cycles per output over each period, so a counter that visits its turnaround value once instead of twice shows up as an odd period length or an odd on-count. The bench writes duty values just after each period starts. A design that loaded them immediately would corrupt the current period in single-update mode. One that ignored the midpoint would leave the second half unchanged in double-update mode.

The bench also covers these cases:
- Widths just under the minimum pulse; a design that mishandles them leaks short pulses.
- A dead value of zero; a design that gets it wrong leaves a one-cycle gap or an overlap.
- The 0x0A7 mask; a design that disables outputs before the swap blanks the wrong pins of leg B.
- Chopping with each enable on its own; a design that gets it wrong chops the side that should stay steady.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  localparam int NLEG = 3;
  localparam int MW   = 3 * NLEG;

  typedef struct packed {
    logic run;
    logic load;
  } tpwm_strobe_t;
endpackage

// File: rtl/tpwm_ctrl.sv
module tpwm_ctrl import tpwm_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dblMode,
  input  logic [CW-1:0] perS,
  output tpwm_strobe_t  stb,
  output logic [CW-1:0] cnt,
  output logic          syncPulse,
  output logic          pwmIrq
);
  logic [CW-1:0] cntQ;
  logic upQ, runQ, syncPrev, irqQ;
  logic atTop, atBottom;

  always_comb begin
    atTop    = ({1'b0, cntQ} + {{CW{1'b0}}, 1'b1}) >= {1'b0, perS};
    atBottom = !upQ && (cntQ == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ     <= '0;
      upQ      <= 1'b0;
      runQ     <= 1'b0;
      syncPrev <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      syncPrev <= syncPulse;
      irqQ     <= syncPulse && !syncPrev;
      if (atBottom) begin
        upQ  <= 1'b1;
        runQ <= 1'b1;
      end else if (upQ && atTop) begin
        upQ <= 1'b0;
      end else if (upQ) begin
        cntQ <= cntQ + 1'b1;
      end else begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end

  assign stb.run   = runQ;
  assign stb.load  = atBottom || (upQ && atTop && dblMode);
  assign cnt       = cntQ;
  assign syncPulse = runQ && upQ && (cntQ == '0);
  assign pwmIrq    = irqQ;

  // R2
  sync_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |=> !syncPulse);

  // R3
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |=> pwmIrq);
endmodule

// File: rtl/tpwm_datapath.sv
module tpwm_datapath import tpwm_pkg::*; #(
  parameter int CW = 16,
  parameter int DW = 10,
  parameter int KW = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tpwm_strobe_t             stb,
  input  logic [CW-1:0]            cnt,
  input  logic [CW-1:0]            periodIn,
  input  logic [DW-1:0]            deadIn,
  input  logic [DW-1:0]            minPulseIn,
  input  logic [NLEG-1:0][CW-1:0]  dutyIn,
  input  logic [MW-1:0]            segMask,
  input  logic                     chopHiEn,
  input  logic                     chopLoEn,
  input  logic [KW-1:0]            chopDiv,
  output logic [CW-1:0]            perS,
  output logic [NLEG-1:0]          gateHi,
  output logic [NLEG-1:0]          gateLo
);
  localparam int SW = CW + 2;

  logic [DW-1:0]           dtS, minS;
  logic [NLEG-1:0][CW-1:0] dutyS;
  logic [MW-1:0]           maskS;
  logic [KW-1:0]           chopCnt;
  logic                    chopWave;
  logic signed [SW-1:0]    pS, tS, mS, cS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perS  <= '0;
      dtS   <= '0;
      minS  <= '0;
      dutyS <= '0;
      maskS <= '0;
    end else if (stb.load) begin
      perS  <= periodIn;
      dtS   <= deadIn;
      minS  <= minPulseIn;
      dutyS <= dutyIn;
      maskS <= segMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chopCnt  <= '0;
      chopWave <= 1'b0;
    end else if (chopCnt == chopDiv) begin
      chopCnt  <= '0;
      chopWave <= ~chopWave;
    end else begin
      chopCnt <= chopCnt + 1'b1;
    end
  end

  always_comb begin
    pS = $signed({2'b00, perS});
    cS = $signed({2'b00, cnt});
    tS = $signed({{(SW-DW){1'b0}}, dtS});
    mS = $signed({{(SW-DW){1'b0}}, minS});
  end

  for (genvar g = 0; g < NLEG; g++) begin : gLeg
    localparam int HB = (g == 0) ? 5 : ((g == 1) ? 2 : 1);
    localparam int LB = (g == 0) ? 4 : ((g == 1) ? 3 : 0);
    localparam int XB = MW - 1 - g;

    logic signed [SW-1:0] dS, hiW, loW;
    logic hiOn, loOn, hiSel, loSel, hiM, loM;

    always_comb begin
      dS    = $signed({2'b00, dutyS[g]});
      hiW   = dS - tS;
      loW   = pS - dS - tS;
      hiOn  = (cS >= (pS - hiW)) && (hiW >= mS);
      loOn  = (cS < loW) && (loW >= mS);
      hiSel = maskS[XB] ? loOn : hiOn;
      loSel = maskS[XB] ? hiOn : loOn;
      hiM   = hiSel && !maskS[HB] && stb.run;
      loM   = loSel && !maskS[LB] && stb.run;
    end

    assign gateHi[g] = hiM && (chopWave || !chopHiEn);
    assign gateLo[g] = loM && (chopWave || !chopLoEn);

    // R5
    leg_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(gateHi[g] && gateLo[g]));
  end

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(perS));
endmodule

// File: rtl/tri_phase_pwm.sv
module tri_phase_pwm import tpwm_pkg::*; #(
  parameter int CW = 16,
  parameter int DW = 10,
  parameter int KW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CW-1:0]   periodIn,
  input  logic [DW-1:0]   deadIn,
  input  logic [DW-1:0]   minPulseIn,
  input  logic [CW-1:0]   dutyA,
  input  logic [CW-1:0]   dutyB,
  input  logic [CW-1:0]   dutyC,
  input  logic [MW-1:0]   segMask,
  input  logic            dblMode,
  input  logic            chopHiEn,
  input  logic            chopLoEn,
  input  logic [KW-1:0]   chopDiv,
  output logic [NLEG-1:0] gateHi,
  output logic [NLEG-1:0] gateLo,
  output logic            syncPulse,
  output logic            pwmIrq
);
  tpwm_strobe_t stb;
  logic [CW-1:0] cnt;
  logic [CW-1:0] perS;

  tpwm_ctrl #(.CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .dblMode(dblMode), .perS(perS),
    .stb(stb), .cnt(cnt), .syncPulse(syncPulse), .pwmIrq(pwmIrq)
  );

  tpwm_datapath #(.CW(CW), .DW(DW), .KW(KW)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .cnt(cnt),
    .periodIn(periodIn), .deadIn(deadIn), .minPulseIn(minPulseIn),
    .dutyIn({dutyC, dutyB, dutyA}), .segMask(segMask),
    .chopHiEn(chopHiEn), .chopLoEn(chopLoEn), .chopDiv(chopDiv),
    .perS(perS), .gateHi(gateHi), .gateLo(gateLo)
  );
endmodule

// File: tb/sim_tri_phase_pwm.sv
module sim_tri_phase_pwm;
  logic clk = 1'b0;
  logic rstN;
  logic [15:0] periodIn, dutyA, dutyB, dutyC;
  logic [9:0]  deadIn, minPulseIn;
  logic [8:0]  segMask;
  logic dblMode, chopHiEn, chopLoEn;
  logic [7:0]  chopDiv;
  logic [2:0]  gateHi, gateLo;
  logic syncPulse, pwmIrq;

  always #2 clk = ~clk;

  tri_phase_pwm u0 (
    .clk(clk), .rstN(rstN), .periodIn(periodIn), .deadIn(deadIn),
    .minPulseIn(minPulseIn), .dutyA(dutyA), .dutyB(dutyB), .dutyC(dutyC),
    .segMask(segMask), .dblMode(dblMode), .chopHiEn(chopHiEn),
    .chopLoEn(chopLoEn), .chopDiv(chopDiv), .gateHi(gateHi),
    .gateLo(gateLo), .syncPulse(syncPulse), .pwmIrq(pwmIrq)
  );

  typedef struct packed {
    logic [15:0]      P;
    logic [9:0]       dt;
    logic [9:0]       minP;
    logic [8:0]       mask;
    logic [2:0][15:0] d;
    logic             dbl;
  } cfg_t;

  typedef struct packed {
    logic [15:0]      len;
    logic [5:0][15:0] on;
  } exp_t;

  int checks = 0, errs = 0;
  bit done = 0;
  exp_t expQ[$];
  string tagQ[$];
  cfg_t cur;
  bit monOn = 0, started = 0;
  int cntOn[6];
  int len, irqCnt, irqIdx;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int sideHalf(cfg_t c, int g, bit hi);
    int w;
    if (hi) w = int'(c.d[g]) - int'(c.dt);
    else    w = int'(c.P) - int'(c.d[g]) - int'(c.dt);
    if (w <= 0 || w < int'(c.minP)) return 0;   // R8
    return (w > int'(c.P)) ? int'(c.P) : w;     // R4
  endfunction

  // index 0..2 = AH,BH,CH ; 3..5 = AL,BL,CL
  function automatic int outHalf(cfg_t c, int idx);
    int g, dis;
    bit isHi, xo;
    g = idx % 3;
    isHi = (idx < 3);
    xo = c.mask[8-g];                            // R9
    if (isHi) dis = (g == 0) ? 5 : ((g == 1) ? 2 : 1);
    else      dis = (g == 0) ? 4 : ((g == 1) ? 3 : 0);
    if (c.mask[dis]) return 0;                   // R10
    return sideHalf(c, g, isHi ^ xo);
  endfunction

  task automatic apply(cfg_t c);
    periodIn = c.P; deadIn = c.dt; minPulseIn = c.minP; segMask = c.mask;
    dutyA = c.d[0]; dutyB = c.d[1]; dutyC = c.d[2]; dblMode = c.dbl;
  endtask

  task automatic waitSync();
    @(negedge clk);
    while (!syncPulse) @(negedge clk);
  endtask

  task automatic runPeriod(cfg_t nx, string tag);
    exp_t e;
    cfg_t h2;
    waitSync();
    h2 = nx.dbl ? nx : cur;
    e.len = 16'(2 * int'(cur.P));
    for (int i = 0; i < 6; i++) e.on[i] = 16'(outHalf(cur, i) + outHalf(h2, i));
    expQ.push_back(e);
    tagQ.push_back(tag);
    apply(nx);
    cur = nx;
  endtask

  task automatic finalize();
    exp_t e;
    string t;
    if (expQ.size() == 0) begin
      chk(0, "R2 extra period", len, 0);
    end else begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      chk(len == int'(e.len), "R2 period length", len, int'(e.len));
      for (int i = 0; i < 6; i++)
        chk(cntOn[i] == int'(e.on[i]), $sformatf("%s on-count of output %0d", t, i),
            cntOn[i], int'(e.on[i]));
      chk(irqCnt == 1 && irqIdx == 1, "R3 irq position", irqIdx, 1);
    end
  endtask

  // monitor: pops one expected item per completed period
  always @(negedge clk) begin
    if (monOn) begin
      if (syncPulse) begin
        if (started) finalize();
        started = 1;
        len = 0; irqCnt = 0; irqIdx = -1;
        for (int i = 0; i < 6; i++) cntOn[i] = 0;
      end
      if (started) begin
        for (int i = 0; i < 3; i++) begin
          cntOn[i]   += int'(gateHi[i]);
          cntOn[3+i] += int'(gateLo[i]);
        end
        if (pwmIrq) begin irqCnt++; irqIdx = len; end
        len++;
      end
    end
  end

  task automatic measureGap(int expv, string tag);
    bit prev;
    int n;
    int guard;
    guard = 0;
    prev = gateHi[0];
    @(negedge clk);
    while (!(prev && !gateHi[0]) && guard < 500) begin
      prev = gateHi[0];
      @(negedge clk);
      guard++;
    end
    n = 0;
    while (!gateLo[0] && n < 200) begin
      n++;
      @(negedge clk);
    end
    chk(n == expv, tag, n, expv);
  endtask

  task automatic countOnes(output int ah, output int bl);
    ah = 0; bl = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      ah += int'(gateHi[0]);
      bl += int'(gateLo[1]);
    end
  endtask

  function automatic cfg_t mk(int P, int dt, int minP, int mask, int a, int b, int c, bit dbl);
    cfg_t r;
    r.P = 16'(P); r.dt = 10'(dt); r.minP = 10'(minP); r.mask = 9'(mask);
    r.d[0] = 16'(a); r.d[1] = 16'(b); r.d[2] = 16'(c); r.dbl = dbl;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - errs, checks);
      $finish;
    end
  end

  initial begin
    cfg_t c0, c1, c2, c3, c4, c5, c6, c7, c8;
    int ah, bl;
    c0 = mk(20, 2, 0, 9'h000, 10, 4, 16, 0);
    c1 = mk(20, 0, 0, 9'h000, 10, 0, 20, 0);
    c2 = mk(20, 1, 3, 9'h000, 3, 18, 10, 0);
    c3 = mk(20, 2, 0, 9'h0A7, 10, 4, 10, 0);
    c4 = mk(20, 1, 0, 9'h140, 4, 10, 16, 0);
    c5 = mk(30, 2, 0, 9'h000, 15, 5, 25, 0);
    c6 = mk(30, 2, 0, 9'h000, 20, 10, 5, 1);
    c7 = mk(30, 4, 0, 9'h000, 8, 25, 15, 1);
    c8 = mk(30, 2, 0, 9'h000, 12, 12, 12, 0);
    rstN = 1'b0; chopHiEn = 0; chopLoEn = 0; chopDiv = 8'd3;
    apply(c0); cur = c0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(gateHi == 3'b000 && gateLo == 3'b000, "R1 gates in reset",
        int'({gateHi, gateLo}), 0);
    chk(!syncPulse && !pwmIrq, "R1 sync/irq in reset", int'({syncPulse, pwmIrq}), 0);
    rstN = 1'b1;
    monOn = 1;
    runPeriod(c0, "R4");
    runPeriod(c1, "R6");
    runPeriod(c2, "R5");
    runPeriod(c3, "R8");
    runPeriod(c4, "R10");
    runPeriod(c5, "R9");
    runPeriod(c6, "R7");
    runPeriod(c7, "R7");
    runPeriod(c8, "R6");
    runPeriod(c8, "R2");
    waitSync();
    @(negedge clk);
    monOn = 0; started = 0;
    chk(expQ.size() == 0, "R2 all periods seen", expQ.size(), 0);

    // R5: dead band between AH off and AL on
    apply(mk(20, 3, 0, 0, 10, 10, 10, 0));
    waitSync(); waitSync();
    measureGap(6, "R5 dead band 2t");
    apply(mk(20, 0, 0, 0, 10, 10, 10, 0));
    waitSync(); waitSync();
    measureGap(0, "R5 zero dead band");

    // R11: chopping, high side then low side
    apply(mk(20, 0, 0, 0, 20, 0, 10, 0));
    chopHiEn = 1; chopLoEn = 0; chopDiv = 8'd3;
    waitSync(); waitSync();
    countOnes(ah, bl);
    chk(ah == 32, "R11 high side chopped", ah, 32);
    chk(bl == 64, "R11 low side steady", bl, 64);
    chopHiEn = 0; chopLoEn = 1;
    @(negedge clk);
    countOnes(ah, bl);
    chk(ah == 64, "R11 high side steady", ah, 64);
    chk(bl == 32, "R11 low side chopped", bl, 32);

    done = 1;
    $display("%0d/%0d checks passed", checks - errs, checks);
    $finish;
  end
endmodule